// File: doc/BRIEF.md
# Capture/PWM Timer with Sync Chain

This block is a 32-bit time-stamp timer with two operating modes that share one free-running counter. In capture mode, a single input pin is watched for rising edges. Each edge stores the current counter value into one of four capture registers, which are filled in rotation. In asymmetric PWM mode, the same counter wraps at a period value held in capture register 1. A PWM output is driven from a compare value held in capture register 2, with selectable polarity. In PWM mode, writes to these two registers land in shadow copies and take effect only at the period boundary.

Several timers can be chained. A sync input, or a software strobe, loads the counter from a phase register. The sync output can forward the sync event, report the counter-equals-period event, or stay quiet. This lets one timer align the time bases of the timers downstream of it. Software controls and observes the block through a simple single-cycle write port and a combinational read port.

Top module: `cap_pwm_timer`

## Requirements
- R1: After reset the counter is 0, the control word reads 0 (capture mode, counter stopped, sync-in disabled, sync-out select 0), `pwmOut` and `pwmOe` are 0, and all capture registers read 0.
- R2: The register map is: address 0 is control, 1 is the counter, 2 is phase, and 3 to 6 are capture registers 1 to 4. Control bits are: bit 0 mode (1 = PWM), bit 1 polarity, bit 2 run, bit 3 sync-in enable, bits 5:4 sync-out select, and bit 6 software sync. With run = 0 the counter holds its value. With run = 1 it increases by one every clock.
- R3: In capture mode, a clock in which `capIn` is 1 after having been 0 in the previous clock stores the counter value of that clock into capture registers 1, 2, 3, 4, 1, ... in turn.
- R4: In PWM mode, `capIn` edges change no capture register.
- R5: In PWM mode with run = 1, the counter counts 0, 1, ..., P and then returns to 0, where P is the active value of capture register 1.
- R6: In PWM mode, `pwmOut` equals (counter < C) XOR polarity, where C is the active value of capture register 2.
- R7: In PWM mode, writes to capture registers 1 and 2 go to shadow copies. The active values, which are also the values read back, change only in the clock after the counter equals the period.
- R8: In capture mode, the counter is never cleared by a counter-equals-period match.
- R9: With sync-in enabled, a `syncIn` pulse or a software sync loads the counter with the phase register in the next clock. This load takes priority over the period wrap and the increment. With sync-in disabled, both are ignored. A control write that sets bit 6 uses the enable and select bits written with it.
- R10: The sync-out select works as follows. Value 0 drives `syncOut` with `syncIn` OR the software sync strobe. Value 1 drives it with the counter-equals-capture-register-1 match. Values 2 and 3 hold it at 0.
- R11: Software sync bit 6 is a one-cycle strobe and always reads back as 0.
- R12: `pwmOe` is 1 exactly when the block is in PWM mode, and `pwmOut` is 0 in capture mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register (combinational) |
| capIn | input | 1 | Capture input pin (synchronous to clk) |
| syncIn | input | 1 | Sync pulse from the upstream timer |
| syncOut | output | 1 | Sync pulse to downstream timers |
| pwmOut | output | 1 | PWM output level |
| pwmOe | output | 1 | Output enable for the shared pin (1 in PWM mode) |

## Verification
Two events can fall in the same clock: the phase load and the period wrap. In that clock, the counter sits at the period value and a sync pulse arrives. The bench provokes this by polling the counter over the read port until it equals the period, then raising `syncIn` for exactly that clock. It judges the result by requiring that the next counter value be the phase value, not 0. The same collision appears on the output side when sync-out select 1 is active: the period match must still appear on `syncOut` in that clock.

// File: rtl/cptmr_pkg.sv
package cptmr_pkg;
  localparam int CAP_NUM    = 4;
  localparam int CAP_PTR_W  = $clog2(CAP_NUM);
  localparam int SHADOW_NUM = 2;
  localparam int CTRL_W     = 7;
  localparam int CTRL_ADDR  = 0;
  localparam int CNT_ADDR   = 1;
  localparam int PHASE_ADDR = 2;
  localparam int CAP_BASE   = 3;
  localparam int BIT_MODE   = 0;
  localparam int BIT_POL    = 1;
  localparam int BIT_RUN    = 2;
  localparam int BIT_SYNCEN = 3;
  localparam int BIT_SOSEL  = 4;
  localparam int BIT_SWSYNC = 6;

  typedef struct packed {
    logic                  cntWrite;
    logic                  phaseWrite;
    logic                  phaseLoad;
    logic                  cntClear;
    logic                  cntInc;
    logic                  capLoad;
    logic [CAP_PTR_W-1:0]  capSel;
    logic [CAP_NUM-1:0]    capWrite;
    logic [SHADOW_NUM-1:0] shadowWrite;
    logic                  shadowXfer;
  } tmrStrobe_t;
endpackage

// File: rtl/cptmr_ctrl.sv
module cptmr_ctrl
  import cptmr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CTRL_W-1:0]    ctrlWdata,
  input  logic                 capIn,
  input  logic                 syncIn,
  input  logic                 prdEvt,
  output tmrStrobe_t           strb,
  output logic [CTRL_W-1:0]    ctrlWord,
  output logic                 pwmMode,
  output logic                 polarity,
  output logic                 syncOut
);
  logic                 modeR, polR, runR, syncEnR, capPrev;
  logic [1:0]           soSelR;
  logic [CAP_PTR_W-1:0] capPtr;
  logic                 wrCtrl, swSync, effSyncEn, syncEvt, capEdge;
  logic [1:0]           effSoSel;

  assign wrCtrl    = busWr && (busAddr == ADDR_W'(CTRL_ADDR));
  assign swSync    = wrCtrl && ctrlWdata[BIT_SWSYNC];
  assign effSyncEn = wrCtrl ? ctrlWdata[BIT_SYNCEN] : syncEnR;
  assign effSoSel  = wrCtrl ? ctrlWdata[BIT_SOSEL +: 2] : soSelR;
  assign syncEvt   = syncIn | swSync;
  assign capEdge   = capIn & ~capPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR   <= 1'b0;
      polR    <= 1'b0;
      runR    <= 1'b0;
      syncEnR <= 1'b0;
      soSelR  <= 2'd0;
      capPrev <= 1'b0;
      capPtr  <= '0;
    end else begin
      capPrev <= capIn;
      if (wrCtrl) begin
        modeR   <= ctrlWdata[BIT_MODE];
        polR    <= ctrlWdata[BIT_POL];
        runR    <= ctrlWdata[BIT_RUN];
        syncEnR <= ctrlWdata[BIT_SYNCEN];
        soSelR  <= ctrlWdata[BIT_SOSEL +: 2];
      end
      if (strb.capLoad) capPtr <= capPtr + 1'b1;
    end
  end

  always_comb begin
    strb            = '0;
    strb.cntWrite   = busWr && (busAddr == ADDR_W'(CNT_ADDR));
    strb.phaseWrite = busWr && (busAddr == ADDR_W'(PHASE_ADDR));
    strb.phaseLoad  = effSyncEn && syncEvt;
    strb.cntClear   = modeR && runR && prdEvt;
    strb.cntInc     = runR;
    strb.capLoad    = !modeR && capEdge;
    strb.capSel     = capPtr;
    strb.shadowXfer = modeR && runR && prdEvt;
    for (int i = 0; i < CAP_NUM; i++) begin
      strb.capWrite[i] = busWr && (busAddr == ADDR_W'(CAP_BASE + i))
                         && ((i >= SHADOW_NUM) || !modeR);
    end
    for (int i = 0; i < SHADOW_NUM; i++) begin
      strb.shadowWrite[i] = busWr && (busAddr == ADDR_W'(CAP_BASE + i));
    end
  end

  always_comb begin
    case (effSoSel)
      2'd0:    syncOut = syncEvt;
      2'd1:    syncOut = prdEvt;
      default: syncOut = 1'b0;
    endcase
  end

  assign ctrlWord = {1'b0, soSelR, syncEnR, runR, polR, modeR};
  assign pwmMode  = modeR;
  assign polarity = polR;

  AST_SYNCOUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (soSelR[1] && !wrCtrl) |-> !syncOut); // R10
  AST_CAP_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capLoad && capPtr == CAP_PTR_W'(CAP_NUM - 1)) |=> (capPtr == '0)); // R3
endmodule

// File: rtl/cptmr_dp.sv
module cptmr_dp
  import cptmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic              pwmMode,
  input  logic              polarity,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [CNT_W-1:0]  busRdata,
  output logic              prdEvt,
  output logic              pwmOut
);
  logic [CNT_W-1:0]     cntQ, phaseQ;
  logic [CNT_W-1:0]     capVal [CAP_NUM];
  logic [CAP_PTR_W-1:0] rdIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      phaseQ <= '0;
    end else begin
      if (strb.cntWrite)       cntQ <= busWdata;
      else if (strb.phaseLoad) cntQ <= phaseQ;
      else if (strb.cntClear)  cntQ <= '0;
      else if (strb.cntInc)    cntQ <= cntQ + 1'b1;
      if (strb.phaseWrite) phaseQ <= busWdata;
    end
  end

  for (genvar i = 0; i < CAP_NUM; i++) begin : g_cap
    logic [CNT_W-1:0] capR;
    if (i < SHADOW_NUM) begin : g_shadowed
      logic [CNT_W-1:0] shadowR;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          capR    <= '0;
          shadowR <= '0;
        end else begin
          if (strb.shadowWrite[i]) shadowR <= busWdata;
          if (strb.capWrite[i])                                        capR <= busWdata;
          else if (strb.shadowXfer)                                    capR <= shadowR;
          else if (strb.capLoad && strb.capSel == CAP_PTR_W'(i))       capR <= cntQ;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                                                     capR <= '0;
        else if (strb.capWrite[i])                                     capR <= busWdata;
        else if (strb.capLoad && strb.capSel == CAP_PTR_W'(i))         capR <= cntQ;
      end
    end
    assign capVal[i] = capR;
  end

  assign prdEvt = (cntQ == capVal[0]);
  assign pwmOut = pwmMode && ((cntQ < capVal[1]) ^ polarity);
  assign rdIdx  = CAP_PTR_W'(busAddr - ADDR_W'(CAP_BASE));

  always_comb begin
    if (busAddr == ADDR_W'(CTRL_ADDR))        busRdata = CNT_W'(ctrlWord);
    else if (busAddr == ADDR_W'(CNT_ADDR))    busRdata = cntQ;
    else if (busAddr == ADDR_W'(PHASE_ADDR))  busRdata = phaseQ;
    else if (busAddr >= ADDR_W'(CAP_BASE) && busAddr < ADDR_W'(CAP_BASE + CAP_NUM))
                                              busRdata = capVal[rdIdx];
    else                                      busRdata = '0;
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntInc && !strb.cntWrite && !strb.phaseLoad) |=> $stable(cntQ)); // R2
  AST_NO_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmMode && strb.cntInc && !strb.cntWrite && !strb.phaseLoad)
      |=> (cntQ == $past(cntQ) + 1'b1)); // R8
  AST_PHASE_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phaseLoad && !strb.cntWrite) |=> (cntQ == $past(phaseQ))); // R9
  AST_CAP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && !strb.capWrite[CAP_NUM-1]) |=> $stable(capVal[CAP_NUM-1])); // R4
endmodule

// File: rtl/cap_pwm_timer.sv
module cap_pwm_timer
  import cptmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              capIn,
  input  logic              syncIn,
  output logic              syncOut,
  output logic              pwmOut,
  output logic              pwmOe
);
  tmrStrobe_t        strb;
  logic [CTRL_W-1:0] ctrlWord;
  logic              pwmMode, polarity, prdEvt;

  cptmr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .ctrlWdata(busWdata[CTRL_W-1:0]), .capIn(capIn), .syncIn(syncIn),
    .prdEvt(prdEvt), .strb(strb), .ctrlWord(ctrlWord), .pwmMode(pwmMode),
    .polarity(polarity), .syncOut(syncOut)
  );

  cptmr_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pwmMode(pwmMode), .polarity(polarity),
    .busAddr(busAddr), .busWdata(busWdata), .ctrlWord(ctrlWord),
    .busRdata(busRdata), .prdEvt(prdEvt), .pwmOut(pwmOut)
  );

  assign pwmOe = pwmMode;

  AST_PWM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pwmOe |-> !pwmOut); // R12
endmodule

// File: tb/test_cap_pwm_timer.sv
module test_cap_pwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, capIn = 1'b0, syncIn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [W-1:0] busWdata = '0, busRdata;
  logic syncOut, pwmOut, pwmOe;
  int checks = 0, errors = 0;

  cap_pwm_timer i_cap_pwm_timer (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .capIn(capIn), .syncIn(syncIn), .syncOut(syncOut),
    .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitCnt(input logic [W-1:0] v);
    logic [W-1:0] c;
    for (int i = 0; i < 400; i++) begin
      rd(3'd1, c);
      if (c == v) return;
      @(negedge clk);
    end
    chk("waitCnt", c, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] v, c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 cnt", v, 0);
    for (int i = 0; i < 4; i++) begin rd(3'(3 + i), v); chk("R1 cap", v, 0); end
    chk("R1 pwmOut", W'(pwmOut), 0);
    chk("R1 pwmOe", W'(pwmOe), 0);
    chk("R1 syncOut", W'(syncOut), 0);

    // R2 frozen then running
    repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R2 frozen", v, 0);
    wr(3'd0, 32'h04);
    rd(3'd1, c0);
    repeat (7) @(negedge clk);
    rd(3'd1, v); chk("R2 run", v, c0 + 7);
    wr(3'd0, 32'h00);
    rd(3'd1, c0);
    repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R2 refreeze", v, c0);

    // R8 no clear at match in capture mode
    wr(3'd3, 32'd3);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h04);
    rd(3'd1, c0);
    repeat (10) @(negedge clk);
    rd(3'd1, v); chk("R8 no wrap", v, c0 + 10);

    // R3 capture rotation
    for (int k = 0; k < 6; k++) begin
      rd(3'd1, c0);
      capIn = 1'b1;
      @(negedge clk);
      capIn = 1'b0;
      @(negedge clk);
      rd(3'(3 + (k % 4)), v); chk("R3 capture", v, c0);
      repeat (k) @(negedge clk);
    end

    // R4 no captures in PWM mode
    rd(3'd5, c0);
    wr(3'd0, 32'h01);
    capIn = 1'b1; @(negedge clk); capIn = 1'b0; @(negedge clk);
    capIn = 1'b1; @(negedge clk); capIn = 1'b0; @(negedge clk);
    rd(3'd5, v); chk("R4 cap3 hold", v, c0);
    rd(3'd6, c0);
    capIn = 1'b1; @(negedge clk); capIn = 1'b0; @(negedge clk);
    rd(3'd6, v); chk("R4 cap4 hold", v, c0);

    // R5 / R6 / R12 sweep of period, compare and polarity
    for (int p = 3; p <= 5; p += 2) begin
      for (int cmp = 0; cmp <= p + 1; cmp++) begin
        for (int pol = 0; pol < 2; pol++) begin
          wr(3'd0, 32'h00);
          wr(3'd3, W'(p));
          wr(3'd4, W'(cmp));
          wr(3'd1, 32'd0);
          wr(3'd0, W'(32'h05 | (pol << 1)));
          chk("R12 oe", W'(pwmOe), 1);
          for (int i = 0; i < 2 * (p + 1); i++) begin
            rd(3'd1, v);
            chk("R5 wrap", v, W'(i % (p + 1)));
            chk("R6 pwm", W'(pwmOut), W'(((i % (p + 1)) < cmp) ? (1 - pol) : pol));
            @(negedge clk);
          end
        end
      end
    end
    wr(3'd0, 32'h00);
    chk("R12 capture out", W'(pwmOut), 0);
    chk("R12 capture oe", W'(pwmOe), 0);

    // R7 shadow transfer at the period boundary
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd2);
    wr(3'd1, 32'd0);
    wr(3'd0, 32'h05);
    waitCnt(1);
    wr(3'd3, 32'd7);
    rd(3'd3, v); chk("R7 active held", v, 5);
    waitCnt(5);
    @(negedge clk);
    rd(3'd1, v); chk("R7 wrap old period", v, 0);
    rd(3'd3, v); chk("R7 new period", v, 7);
    repeat (7) @(negedge clk);
    rd(3'd1, v); chk("R7 reaches 7", v, 7);
    @(negedge clk);
    rd(3'd1, v); chk("R7 wraps at 7", v, 0);

    // R9 phase load: disabled, then colliding with the period wrap
    wr(3'd2, 32'd4);
    rd(3'd1, c0);
    syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
    rd(3'd1, v); chk("R9 ignored", v, (c0 + 1) % 8);
    wr(3'd0, 32'h0D);
    waitCnt(7);
    syncIn = 1'b1; @(negedge clk); syncIn = 1'b0;
    rd(3'd1, v); chk("R9 phase over wrap", v, 4);
    waitCnt(1);
    wr(3'd0, 32'h4D);
    rd(3'd1, v); chk("R9 software sync", v, 4);
    rd(3'd0, v); chk("R11 readback", v, 32'h0D);

    // R10 sync-out select
    @(negedge clk);
    syncIn = 1'b1; #1; chk("R10 sel0 pass", W'(syncOut), 1);
    syncIn = 1'b0; #1; chk("R10 sel0 idle", W'(syncOut), 0);
    @(negedge clk);
    busWr = 1'b1; busAddr = 3'd0; busWdata = 32'h45; #1;
    chk("R10 sel0 software", W'(syncOut), 1);
    @(negedge clk); busWr = 1'b0;
    #1; chk("R11 strobe ends", W'(syncOut), 0);
    wr(3'd0, 32'h2D);
    syncIn = 1'b1; #1; chk("R10 sel2 off", W'(syncOut), 0);
    @(negedge clk); syncIn = 1'b0;
    wr(3'd0, 32'h3D);
    syncIn = 1'b1; #1; chk("R10 sel3 off", W'(syncOut), 0);
    @(negedge clk); syncIn = 1'b0;
    wr(3'd0, 32'h15);
    waitCnt(7);
    chk("R10 sel1 period", W'(syncOut), 1);
    @(negedge clk);
    #1; chk("R10 sel1 after", W'(syncOut), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule